// File: doc/BRIEF.md
# Line-Gated Vertical Sensor-Gate Pulse Generator

This block drives two sensor-gate pulses for a CCD timing generator. Within each field it picks one line, counted by horizontal sync edges after vertical sync. On that line it starts a 13-bit pixel counter. Each of the two outputs is high for a programmed number of pixel clocks, starting at a programmed pixel position. The pixel counter is not cleared by later horizontal syncs, so a pulse placed near the end of a line continues unbroken into the next line.

Two start positions are stored. A one-bit selector per output chooses which of the two positions drives that output, and both outputs share one length value. The outputs are gated by a sparse mask field and by a global enable. Every setting is copied into shadow registers on the vertical sync edge, so a new value first affects the field that begins after it is written. The block has only plain control pins. No data stream passes through it, so there is no valid/ready handshake and no back-pressure.

Top module: `sgate_pulse_gen`

## Requirements
- R1: After the synchronous active-high reset, both outputs are low. They stay low, even while sync pulses arrive, until a vertical sync edge has loaded a configuration that enables them.
- R2: The first rising edge of `hsync` after a rising edge of `vsync` begins line 0. The pixel counter starts on the `hsync` rising edge that begins line `cfg_line` (0 to 127). So `cfg_line` = 3 places the pulse in the fourth line.
- R3: Let E be the clock edge on which `hsync` is first sampled high for the active line, S the start position selected for an output, and L the length. That output is high after edges E+S+1 through E+S+L, which is L cycles. It is low in every other cycle of the field.
- R4: `cfg_sel_1` and `cfg_sel_2` each choose the start position for their own output: 0 selects `cfg_pos_a` and 1 selects `cfg_pos_b`. Both outputs may select the same position.
- R5: Horizontal sync edges after the active line neither clear nor restart the pixel counter, so a pulse that crosses a line boundary keeps its full width.
- R6: The pixel counter stops at 8191 and stays there until the next vertical sync. The pulse window is clipped there, giving a width of min(S+L, 8192) − S. At most one pulse per output occurs in each field.
- R7: Bit 1 of `cfg_mask` unmasks output 1 and bit 3 unmasks output 2. The codes are 0x00 (both masked), 0x02 (only output 1), 0x08 (only output 2) and 0x0A (both). Bits 0, 2, 4 and 5 are ignored.
- R8: With `cfg_en` = 0, both outputs stay low for the whole field, whatever the mask holds.
- R9: A length of 0 produces no pulse on either output.
- R10: All configuration inputs are captured on the clock edge where `vsync` is first sampled high. Changing them later in the field does not alter that field's pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| vsync | input | 1 | Vertical sync; rising edge starts a field |
| hsync | input | 1 | Horizontal sync; rising edge starts a line |
| cfg_pos_a | input | 13 | First stored start position, in pixel clocks |
| cfg_pos_b | input | 13 | Second stored start position, in pixel clocks |
| cfg_len | input | 8 | Pulse length shared by both outputs |
| cfg_sel_1 | input | 1 | Position selector for output 1 |
| cfg_sel_2 | input | 1 | Position selector for output 2 |
| cfg_line | input | 7 | Index of the line that carries the pulses |
| cfg_mask | input | 6 | Sparse output mask (bit 1 and bit 3 used) |
| cfg_en | input | 1 | Global output enable |
| gate_1 | output | 1 | Sensor-gate pulse 1, registered, active high |
| gate_2 | output | 1 | Sensor-gate pulse 2, registered, active high |

## Verification
Fields are run with the active line near the start of the field and deep into it (line 100). This separates correct line counting from a counter that starts on the wrong horizontal sync. Short line periods push pulses across several line boundaries, which exposes any restart of the pixel counter. Start positions near 8191 tell clipping at saturation apart from wrap-around. Mixed selector values, the four mask codes plus codes with stray bits, enable off and zero length isolate the routing and gating paths. Each field also rewrites every configuration input just after vertical sync, so a block that skips the shadow copy produces a different pulse.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
  localparam int PIX_W     = 13;
  localparam int LEN_W     = 8;
  localparam int LINE_W    = 7;
  localparam int MASK_W    = 6;
  localparam int NUM_GATES = 2;

  typedef struct packed {
    logic [PIX_W-1:0]     pos_a;
    logic [PIX_W-1:0]     pos_b;
    logic [LEN_W-1:0]     len;
    logic [NUM_GATES-1:0] sel;
    logic [LINE_W-1:0]    line;
    logic [NUM_GATES-1:0] unmask;
    logic                 en;
  } sgp_cfg_t;

  // mask bit that unmasks gate i (sparse code: bits 1, 3, ...)
  function automatic int unmask_bit(input int i);
    return 2 * i + 1;
  endfunction
endpackage

// File: rtl/sgp_edge_det.sv
module sgp_edge_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] din_q;

  always_ff @(posedge clk) begin
    if (rst) din_q <= '0;
    else     din_q <= din;
  end

  assign rise = din & ~din_q;
endmodule

// File: rtl/sgp_line_tracker.sv
module sgp_line_tracker #(
  parameter int LINE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vd_rise,
  input  logic              hd_rise,
  input  logic [LINE_W-1:0] act_line,
  output logic              start
);
  localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

  logic [LINE_W-1:0] line_cnt;
  logic              fired;

  assign start = hd_rise && !vd_rise && !fired && (line_cnt == act_line);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_cnt <= '0;
      fired    <= 1'b0;
    end else if (vd_rise) begin
      line_cnt <= '0;
      fired    <= 1'b0;
    end else if (hd_rise) begin
      if (start) fired <= 1'b1;
      if (line_cnt != LINE_MAX) line_cnt <= line_cnt + 1'b1;
    end
  end

  // R2: a new field restarts the line count from zero
  p_line_clear_r2: assert property (@(posedge clk) disable iff (rst)
    vd_rise |=> (line_cnt == '0) && !fired);

  // R6: once the pulse line has fired, no second start in the field
  p_one_start_r6: assert property (@(posedge clk) disable iff (rst)
    (fired && !vd_rise) |=> fired);
endmodule

// File: rtl/sgp_pixel_timer.sv
module sgp_pixel_timer #(
  parameter int PIX_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vd_rise,
  input  logic             start,
  output logic [PIX_W-1:0] pix,
  output logic             active
);
  localparam logic [PIX_W-1:0] PIX_MAX = {PIX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      pix    <= '0;
      active <= 1'b0;
    end else if (vd_rise) begin
      pix    <= '0;
      active <= 1'b0;
    end else if (start) begin
      pix    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (pix == PIX_MAX) active <= 1'b0;
      else                pix    <= pix + 1'b1;
    end
  end

  // R6: counter stops at its top value and drops out of the active state
  p_pix_sat_r6: assert property (@(posedge clk) disable iff (rst)
    (active && pix == PIX_MAX && !vd_rise && !start) |=> (!active && pix == PIX_MAX));

  // R5: later line syncs do not disturb a running count
  p_no_restart_r5: assert property (@(posedge clk) disable iff (rst)
    (active && pix != PIX_MAX && !vd_rise && !start) |=> (pix == $past(pix) + 1'b1));
endmodule

// File: rtl/sgp_gate_out.sv
module sgp_gate_out #(
  parameter int PIX_W = 13,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix,
  input  logic             active,
  input  logic [PIX_W-1:0] start_pos,
  input  logic [LEN_W-1:0] len,
  input  logic             gate_en,
  output logic             gate
);
  logic [PIX_W:0] win_end;
  logic           in_win;

  assign win_end = {1'b0, start_pos} + {{(PIX_W+1-LEN_W){1'b0}}, len};
  assign in_win  = active && (pix >= start_pos) && ({1'b0, pix} < win_end);

  always_ff @(posedge clk) begin
    if (rst) gate <= 1'b0;
    else     gate <= in_win && gate_en;
  end

  // R7 R8: a gated-off output stays low
  p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> !gate);

  // R9: zero length never produces a pulse
  p_len_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (len == '0) |=> !gate);

  // R3: a pulse only appears while the pixel counter was running
  p_gate_in_run_r3: assert property (@(posedge clk) disable iff (rst)
    gate |-> $past(active));
endmodule

// File: rtl/sgate_pulse_gen.sv
module sgate_pulse_gen
  import sgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              vsync,
  input  logic              hsync,
  input  logic [PIX_W-1:0]  cfg_pos_a,
  input  logic [PIX_W-1:0]  cfg_pos_b,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_sel_1,
  input  logic              cfg_sel_2,
  input  logic [LINE_W-1:0] cfg_line,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              cfg_en,
  output logic              gate_1,
  output logic              gate_2
);
  logic [1:0]           sync_rise;
  logic                 vd_rise, hd_rise;
  sgp_cfg_t             cfg_in, shadow;
  logic                 start;
  logic [PIX_W-1:0]     pix;
  logic                 active;
  logic [NUM_GATES-1:0] gate_vec;
  logic [MASK_W-1:0]    mask_unused;

  sgp_edge_det #(.W(2)) u_edges (
    .clk (clk), .rst (rst), .din ({hsync, vsync}), .rise (sync_rise)
  );
  assign vd_rise = sync_rise[0];
  assign hd_rise = sync_rise[1];

  // gather configuration; only the sparse unmask bits are kept
  always_comb begin
    mask_unused  = cfg_mask;
    cfg_in.pos_a = cfg_pos_a;
    cfg_in.pos_b = cfg_pos_b;
    cfg_in.len   = cfg_len;
    cfg_in.sel   = {cfg_sel_2, cfg_sel_1};
    cfg_in.line  = cfg_line;
    cfg_in.en    = cfg_en;
    for (int i = 0; i < NUM_GATES; i++) begin
      cfg_in.unmask[i]            = cfg_mask[unmask_bit(i)];
      mask_unused[unmask_bit(i)]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          shadow <= '0;
    else if (vd_rise) shadow <= cfg_in;
  end

  sgp_line_tracker #(.LINE_W(LINE_W)) u_lines (
    .clk (clk), .rst (rst), .vd_rise (vd_rise), .hd_rise (hd_rise),
    .act_line (shadow.line), .start (start)
  );

  sgp_pixel_timer #(.PIX_W(PIX_W)) u_pix (
    .clk (clk), .rst (rst), .vd_rise (vd_rise), .start (start),
    .pix (pix), .active (active)
  );

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    logic [PIX_W-1:0] sel_pos;
    assign sel_pos = shadow.sel[g] ? shadow.pos_b : shadow.pos_a;

    sgp_gate_out #(.PIX_W(PIX_W), .LEN_W(LEN_W)) u_gate (
      .clk (clk), .rst (rst), .pix (pix), .active (active),
      .start_pos (sel_pos), .len (shadow.len),
      .gate_en (shadow.en && shadow.unmask[g]), .gate (gate_vec[g])
    );
  end

  assign gate_1 = gate_vec[0];
  assign gate_2 = gate_vec[1];

  // R10: shadow copy only moves on a field start
  p_shadow_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !vd_rise |=> $stable(shadow));

  // R1: outputs are low in the first cycle after reset
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (!gate_1 && !gate_2));
endmodule

// File: tb/test_sgate_pulse_gen.sv
module test_sgate_pulse_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        vsync, hsync;
  logic [12:0] cfg_pos_a, cfg_pos_b;
  logic [7:0]  cfg_len;
  logic        cfg_sel_1, cfg_sel_2;
  logic [6:0]  cfg_line;
  logic [5:0]  cfg_mask;
  logic        cfg_en;
  logic        gate_1, gate_2;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  sgate_pulse_gen i_sgate_pulse_gen (
    .clk (clk), .rst (rst), .vsync (vsync), .hsync (hsync),
    .cfg_pos_a (cfg_pos_a), .cfg_pos_b (cfg_pos_b), .cfg_len (cfg_len),
    .cfg_sel_1 (cfg_sel_1), .cfg_sel_2 (cfg_sel_2), .cfg_line (cfg_line),
    .cfg_mask (cfg_mask), .cfg_en (cfg_en), .gate_1 (gate_1), .gate_2 (gate_2)
  );

  // ---- reference model built from the requirements ----
  bit m_vprev, m_hprev, m_act, m_fired;
  int m_line, m_pix;
  int s_pa, s_pb, s_len, s_line;
  bit s_s1, s_s2, s_u1, s_u2, s_en;
  bit exp1, exp2;

  function automatic bit in_win(int pix, int st, int len);
    return (pix >= st) && (pix < st + len);
  endfunction

  function automatic int exp_width(int st, int len);
    if (len == 0) return 0;
    if (st + len > 8192) return 8192 - st;
    return len;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_vprev = 0; m_hprev = 0; m_act = 0; m_fired = 0; m_line = 0; m_pix = 0;
      s_pa = 0; s_pb = 0; s_len = 0; s_line = 0;
      s_s1 = 0; s_s2 = 0; s_u1 = 0; s_u2 = 0; s_en = 0;
      exp1 = 0; exp2 = 0;
    end else begin
      exp1 = m_act && s_en && s_u1 && in_win(m_pix, s_s1 ? s_pb : s_pa, s_len);
      exp2 = m_act && s_en && s_u2 && in_win(m_pix, s_s2 ? s_pb : s_pa, s_len);
      if (vsync && !m_vprev) begin
        s_pa = cfg_pos_a; s_pb = cfg_pos_b; s_len = cfg_len; s_line = cfg_line;
        s_s1 = cfg_sel_1; s_s2 = cfg_sel_2; s_en = cfg_en;
        s_u1 = cfg_mask[1]; s_u2 = cfg_mask[3];
        m_line = 0; m_fired = 0; m_act = 0; m_pix = 0;
      end else begin
        if (hsync && !m_hprev && !m_fired && m_line == s_line) begin
          m_pix = 0; m_act = 1; m_fired = 1;
        end else if (m_act) begin
          if (m_pix == 8191) m_act = 0;
          else m_pix++;
        end
        if (hsync && !m_hprev && m_line < 127) m_line++;
      end
      m_vprev = vsync; m_hprev = hsync;
    end
  end

  // ---- per-field observation at the falling edge ----
  int mism1, mism2, hi1, hi2;
  bit first1;
  int got1, want1;
  always @(negedge clk) begin
    if (!rst) begin
      if (gate_1) hi1++;
      if (gate_2) hi2++;
      if (gate_1 !== exp1) begin
        if (!first1) begin got1 = gate_1; want1 = exp1; first1 = 1; end
        mism1++;
      end
      if (gate_2 !== exp2) mism2++;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, expv);
    end
  endtask

  task automatic run_field(input int pa, input int pb, input int len, input bit s1,
                           input bit s2, input int line, input int mask, input bit en,
                           input int period, input string tag);
    int n_lines;
    int w1, w2;
    @(negedge clk);
    cfg_pos_a = 13'(pa); cfg_pos_b = 13'(pb); cfg_len = 8'(len);
    cfg_sel_1 = s1; cfg_sel_2 = s2; cfg_line = 7'(line);
    cfg_mask = 6'(mask); cfg_en = en;
    vsync = 1'b1;
    mism1 = 0; mism2 = 0; hi1 = 0; hi2 = 0; first1 = 0;
    @(negedge clk);
    @(negedge clk);
    vsync = 1'b0;
    // R10: scramble every setting after the field has started
    cfg_pos_a = 13'($urandom); cfg_pos_b = 13'($urandom); cfg_len = 8'($urandom);
    cfg_sel_1 = 1'($urandom); cfg_sel_2 = 1'($urandom); cfg_line = 7'($urandom);
    cfg_mask = 6'($urandom); cfg_en = 1'($urandom);
    n_lines = line + 8400 / period + 2;
    for (int k = 0; k < n_lines; k++) begin
      repeat (period - 1) @(negedge clk);
      hsync = 1'b1;
      @(negedge clk);
      hsync = 1'b0;
    end
    repeat (4) @(negedge clk);
    w1 = (en && mask[1]) ? exp_width(s1 ? pb : pa, len) : 0;
    w2 = (en && mask[3]) ? exp_width(s2 ? pb : pa, len) : 0;
    check(mism1 == 0, {tag, " R3 gate_1 cycle match"}, got1, want1);
    check(mism2 == 0, {tag, " R3 gate_2 mismatched cycles"}, mism2, 0);
    check(hi1 == w1, {tag, " gate_1 width"}, hi1, w1);
    check(hi2 == w2, {tag, " gate_2 width"}, hi2, w2);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    rst = 1'b1; vsync = 0; hsync = 0;
    cfg_pos_a = 0; cfg_pos_b = 0; cfg_len = 0; cfg_sel_1 = 0; cfg_sel_2 = 0;
    cfg_line = 0; cfg_mask = 0; cfg_en = 0;
    repeat (4) @(negedge clk);
    check(gate_1 == 0 && gate_2 == 0, "R1 outputs low in reset", {gate_1, gate_2}, 0);
    rst = 1'b0;
    // R1: sync activity before any configured field keeps outputs low
    hi1 = 0; hi2 = 0;
    for (int k = 0; k < 6; k++) begin
      repeat (20) @(negedge clk);
      hsync = 1'b1; @(negedge clk); hsync = 1'b0;
    end
    repeat (50) @(negedge clk);
    check(hi1 == 0 && hi2 == 0, "R1 quiet before first field", hi1 + hi2, 0);

    run_field(10, 400, 5, 0, 0, 3, 'h0A, 1, 100, "R2 fourth line");
    run_field(20, 300, 17, 1, 0, 1, 'h0A, 1, 150, "R4 split selectors");
    run_field(20, 300, 17, 0, 1, 0, 'h0A, 1, 150, "R4 swapped selectors");
    run_field(40, 40, 9, 0, 0, 2, 'h02, 1, 120, "R7 only output 1");
    run_field(40, 40, 9, 0, 0, 2, 'h08, 1, 120, "R7 only output 2");
    run_field(40, 40, 9, 0, 0, 2, 'h35, 1, 120, "R7 stray bits only");
    run_field(40, 40, 9, 0, 0, 2, 'h00, 1, 120, "R7 both masked");
    run_field(40, 40, 9, 0, 0, 2, 'h0A, 0, 120, "R8 enable off");
    run_field(40, 90, 0, 0, 1, 2, 'h0A, 1, 120, "R9 zero length");
    run_field(50, 30, 200, 0, 1, 4, 'h3F, 1, 64, "R5 spill across lines");
    run_field(8190, 8191, 5, 0, 1, 1, 'h0A, 1, 500, "R6 clip at saturation");
    run_field(5, 7000, 255, 1, 0, 100, 'h0A, 1, 64, "R2 deep line");
    for (int r = 0; r < 5; r++) begin
      int msk;
      msk = int'($urandom_range(0, 63));
      run_field(int'($urandom_range(0, 8191)), int'($urandom_range(0, 8191)),
                int'($urandom_range(0, 255)), 1'($urandom), 1'($urandom),
                int'($urandom_range(0, 5)), msk, ($urandom_range(0, 7) != 0),
                int'($urandom_range(200, 1200)), "R10 random field");
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(199000 * 10);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule